// File: doc/BRIEF.md
# Framebuffer Pixel Format Converting Copier

This block copies a rectangular image from one place in byte-addressed memory to another and repacks every pixel on the way. Each source pixel is four bytes: three color components followed by alpha. Each destination pixel is three bytes. Software loads a small group of configuration words: source and destination base addresses, the programmed source and destination widths, the destination height and a format word. It then writes the trigger word. The engine walks the image row by row. For each pixel it reads the three color bytes through a byte read port and writes them through a byte write port. When it is finished it raises a one-cycle completion pulse.

The programmed widths are twice the real pixel width. The engine therefore runs half the programmed destination width as columns per row, and it uses half of each programmed width when stepping from one row to the next. The alpha byte is never fetched. A format word that does not name the one supported conversion is rejected: the error output goes high and no memory access takes place.

Top module: `pixel_blit_top`

## Requirements
- R1: Configuration word index 6 is the trigger. Writing it with bit 0 set starts a transfer (busy is high from the next cycle). Writing it with bit 0 clear starts nothing: no access, no done pulse, busy stays low.
- R2: Word 5 holds the source format code in bits [3:0] and the destination format code in bits [7:4]. The 4-byte color+alpha code is 0 and the 3-byte color code is 1. A trigger with any other pair sets err, causes no memory access and no done pulse. A later trigger with the valid pair clears err.
- R3: The engine processes rows 0 to H-1, where H is word 4. It processes columns 0 to floor(W_out/2)-1, where W_out is word 3. If either count is zero, done pulses with no memory access.
- R4: The source bytes of pixel (x,y) are read at word0 + 4*x + y*(2*W_in) + k for k = 0, 1, 2, where W_in is word 2. The address at offset 3 (alpha) is never read.
- R5: The destination bytes of pixel (x,y) are written at word1 + 3*x + y*floor(3*W_out/2) + k for k = 0, 1, 2.
- R6: Destination byte k receives source byte k of the same pixel, for k = 0, 1, 2.
- R7: Pixels go in raster order, x fastest. A pixel's three reads all come before its three writes, and read and write are never active together.
- R8: done is a single-cycle pulse in the cycle right after the final byte write. busy is low from the cycle after done.
- R9: While busy, a trigger write is ignored. Configuration writes made during a transfer do not change that transfer.
- R10: After reset busy, done, err, rd_req and wr_en are low.
- R11: Read data is returned on rd_data in the cycle after the rd_req cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_sel | input | 3 | Configuration word index |
| cfg_wdata | input | CFG_W | Configuration write data |
| rd_req | output | 1 | Byte read request |
| rd_addr | output | ADDR_W | Byte read address |
| rd_data | input | 8 | Read byte, one cycle after rd_req |
| wr_en | output | 1 | Byte write strobe |
| wr_addr | output | ADDR_W | Byte write address |
| wr_data | output | 8 | Byte write data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last trigger named an unsupported format pair |

## Verification
A broken column or row counter shows up in the address stream of the next pixel or the next row. It appears as a wrong rd_addr within three cycles of the faulty step, or as done arriving before or after the expected number of writes. A wrong byte-lane capture appears as a wrong wr_data in the very next write phase. A wrong stride shows up only at the first pixel of row 1, so every pattern uses at least two rows with unequal source and destination strides. A latched state that ignores the busy guard shows up as a second done pulse or as extra accesses after completion.

// File: rtl/pbx_pkg.sv
package pbx_pkg;
  localparam logic [3:0] FMT_RGBA8 = 4'd0;
  localparam logic [3:0] FMT_RGB8  = 4'd1;
  localparam int SRC_BPP    = 4;
  localparam int DST_BPP    = 3;
  localparam int COPY_BYTES = 3;
  localparam int NWORDS     = 6;
  localparam int TRIG_IDX   = 6;
  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE, ST_DONE} pbx_state_e;
endpackage

// File: rtl/pbx_regs.sv
module pbx_regs #(
  parameter int ADDR_W = 32,
  parameter int CFG_W  = 32,
  parameter int GEOM_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              busy,
  output logic [ADDR_W-1:0] src_base,
  output logic [ADDR_W-1:0] dst_base,
  output logic [GEOM_W-1:0] src_w,
  output logic [GEOM_W-1:0] dst_w,
  output logic [GEOM_W-1:0] dst_h,
  output logic [3:0]        src_fmt,
  output logic [3:0]        dst_fmt,
  output logic              start
);
  import pbx_pkg::*;

  logic [CFG_W-1:0] word_q [NWORDS];
  logic [CFG_W-1:0] word_d [NWORDS];

  always_comb begin
    for (int w = 0; w < NWORDS; w++) begin
      word_d[w] = word_q[w];
      if (cfg_we && (cfg_sel == 3'(w))) word_d[w] = cfg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < NWORDS; w++) word_q[w] <= '0;
    end else if (cfg_we) begin
      for (int w = 0; w < NWORDS; w++) word_q[w] <= word_d[w];
    end
  end

  assign src_base = word_q[0][ADDR_W-1:0];
  assign dst_base = word_q[1][ADDR_W-1:0];
  assign src_w    = word_q[2][GEOM_W-1:0];
  assign dst_w    = word_q[3][GEOM_W-1:0];
  assign dst_h    = word_q[4][GEOM_W-1:0];
  assign src_fmt  = word_q[5][3:0];
  assign dst_fmt  = word_q[5][7:4];
  assign start    = cfg_we && (cfg_sel == 3'(TRIG_IDX)) && cfg_wdata[0] && !busy;
endmodule

// File: rtl/pbx_walker.sv
module pbx_walker #(
  parameter int ADDR_W = 32,
  parameter int GEOM_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] src_base,
  input  logic [ADDR_W-1:0] dst_base,
  input  logic [GEOM_W-1:0] src_w,
  input  logic [GEOM_W-1:0] dst_w,
  input  logic [GEOM_W-1:0] dst_h,
  output logic [ADDR_W-1:0] src_pix,
  output logic [ADDR_W-1:0] dst_pix,
  output logic              last_pix,
  output logic              empty
);
  import pbx_pkg::*;

  localparam int SSW = GEOM_W + 1;
  localparam int DSW = GEOM_W + 2;

  logic [GEOM_W-1:0] cols_q, cols_d, rows_q, rows_d, x_q, x_d, y_q, y_d;
  logic [ADDR_W-1:0] srow_q, srow_d, scur_q, scur_d, drow_q, drow_d, dcur_q, dcur_d;
  logic [ADDR_W-1:0] sstr_q, sstr_d, dstr_q, dstr_d;
  logic [GEOM_W-1:0] cols_in;
  logic [SSW-1:0]    sstr_in;
  logic [DSW-1:0]    dprod;
  logic              row_end;

  assign cols_in = dst_w >> 1;
  assign sstr_in = {src_w, 1'b0};
  assign dprod   = {2'b00, dst_w} + {1'b0, dst_w, 1'b0};
  assign empty   = (cols_in == '0) || (dst_h == '0);
  assign row_end = (x_q == cols_q - GEOM_W'(1));

  always_comb begin
    cols_d = cols_q; rows_d = rows_q; x_d = x_q; y_d = y_q;
    srow_d = srow_q; scur_d = scur_q; drow_d = drow_q; dcur_d = dcur_q;
    sstr_d = sstr_q; dstr_d = dstr_q;
    if (load) begin
      cols_d = cols_in;
      rows_d = dst_h;
      x_d    = '0;
      y_d    = '0;
      srow_d = src_base;
      scur_d = src_base;
      drow_d = dst_base;
      dcur_d = dst_base;
      sstr_d = ADDR_W'(sstr_in);
      dstr_d = ADDR_W'(dprod >> 1);
    end else if (step) begin
      if (row_end) begin
        x_d    = '0;
        y_d    = y_q + GEOM_W'(1);
        srow_d = srow_q + sstr_q;
        scur_d = srow_q + sstr_q;
        drow_d = drow_q + dstr_q;
        dcur_d = drow_q + dstr_q;
      end else begin
        x_d    = x_q + GEOM_W'(1);
        scur_d = scur_q + ADDR_W'(SRC_BPP);
        dcur_d = dcur_q + ADDR_W'(DST_BPP);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cols_q <= '0; rows_q <= '0; x_q <= '0; y_q <= '0;
      srow_q <= '0; scur_q <= '0; drow_q <= '0; dcur_q <= '0;
      sstr_q <= '0; dstr_q <= '0;
    end else if (load || step) begin
      cols_q <= cols_d; rows_q <= rows_d; x_q <= x_d; y_q <= y_d;
      srow_q <= srow_d; scur_q <= scur_d; drow_q <= drow_d; dcur_q <= dcur_d;
      sstr_q <= sstr_d; dstr_q <= dstr_d;
    end
  end

  assign src_pix  = scur_q;
  assign dst_pix  = dcur_q;
  assign last_pix = row_end && (y_q == rows_q - GEOM_W'(1));
endmodule

// File: rtl/pbx_mover.sv
module pbx_mover #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              fmt_ok,
  input  logic              empty,
  input  logic              last_pix,
  input  logic [ADDR_W-1:0] src_pix,
  input  logic [ADDR_W-1:0] dst_pix,
  input  logic [7:0]        rd_data,
  output logic              load,
  output logic              step,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              busy,
  output logic              done,
  output logic              err
);
  import pbx_pkg::*;

  localparam int BW = $clog2(COPY_BYTES);
  localparam logic [BW-1:0] LAST_B = BW'(COPY_BYTES - 1);

  pbx_state_e    state_q, state_d;
  logic [BW-1:0] bidx_q, bidx_d, pend_idx_q;
  logic          pend_q, err_q, err_d;
  logic [7:0]    lane [COPY_BYTES];

  always_comb begin
    state_d = state_q;
    bidx_d  = bidx_q;
    err_d   = err_q;
    load    = 1'b0;
    step    = 1'b0;
    rd_req  = 1'b0;
    wr_en   = 1'b0;
    done    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          err_d = !fmt_ok;
          if (fmt_ok) begin
            load    = 1'b1;
            bidx_d  = '0;
            state_d = empty ? ST_DONE : ST_READ;
          end
        end
      end
      ST_READ: begin
        rd_req = 1'b1;
        if (bidx_q == LAST_B) begin
          bidx_d  = '0;
          state_d = ST_WRITE;
        end else begin
          bidx_d = bidx_q + BW'(1);
        end
      end
      ST_WRITE: begin
        wr_en = 1'b1;
        if (bidx_q == LAST_B) begin
          bidx_d = '0;
          if (last_pix) begin
            state_d = ST_DONE;
          end else begin
            step    = 1'b1;
            state_d = ST_READ;
          end
        end else begin
          bidx_d = bidx_q + BW'(1);
        end
      end
      ST_DONE: begin
        done    = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      bidx_q     <= '0;
      err_q      <= 1'b0;
      pend_q     <= 1'b0;
      pend_idx_q <= '0;
    end else begin
      state_q    <= state_d;
      bidx_q     <= bidx_d;
      err_q      <= err_d;
      pend_q     <= rd_req;
      pend_idx_q <= bidx_q;
    end
  end

  for (genvar g = 0; g < COPY_BYTES; g++) begin : g_lane
    logic [7:0] byte_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  byte_q <= '0;
      else if (pend_q && (pend_idx_q == BW'(g)))   byte_q <= rd_data;
    end
    assign lane[g] = byte_q;
  end

  assign rd_addr = src_pix + ADDR_W'(bidx_q);
  assign wr_addr = dst_pix + ADDR_W'(bidx_q);
  assign wr_data = lane[bidx_q];
  assign busy    = (state_q != ST_IDLE);
  assign err     = err_q;
endmodule

// File: rtl/pixel_blit_top.sv
module pixel_blit_top #(
  parameter int ADDR_W = 32,
  parameter int CFG_W  = 32,
  parameter int GEOM_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              busy,
  output logic              done,
  output logic              err
);
  import pbx_pkg::*;

  logic [ADDR_W-1:0] src_base, dst_base, src_pix, dst_pix;
  logic [GEOM_W-1:0] src_w, dst_w, dst_h;
  logic [3:0]        src_fmt, dst_fmt;
  logic              start, fmt_ok, load, step, last_pix, empty;

  pbx_regs #(.ADDR_W(ADDR_W), .CFG_W(CFG_W), .GEOM_W(GEOM_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .busy(busy), .src_base(src_base),
    .dst_base(dst_base), .src_w(src_w), .dst_w(dst_w), .dst_h(dst_h),
    .src_fmt(src_fmt), .dst_fmt(dst_fmt), .start(start)
  );

  assign fmt_ok = (src_fmt == FMT_RGBA8) && (dst_fmt == FMT_RGB8);

  pbx_walker #(.ADDR_W(ADDR_W), .GEOM_W(GEOM_W)) walk_i (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step),
    .src_base(src_base), .dst_base(dst_base), .src_w(src_w),
    .dst_w(dst_w), .dst_h(dst_h), .src_pix(src_pix), .dst_pix(dst_pix),
    .last_pix(last_pix), .empty(empty)
  );

  pbx_mover #(.ADDR_W(ADDR_W)) move_i (
    .clk(clk), .rst_n(rst_n), .start(start), .fmt_ok(fmt_ok),
    .empty(empty), .last_pix(last_pix), .src_pix(src_pix),
    .dst_pix(dst_pix), .rd_data(rd_data), .load(load), .step(step),
    .rd_req(rd_req), .rd_addr(rd_addr), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .done(done), .err(err)
  );
endmodule

// File: rtl/pixel_blit_chk.sv
module pixel_blit_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_req,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              busy,
  input logic              done,
  input logic              err
);
  AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && wr_en)); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!rd_req && !wr_en && !done)); // R1
  AST_ERR_NO_ACTIVITY: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!busy && !rd_req && !wr_en)); // R2
  AST_WRITE_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (wr_en || rd_req || done)); // R8
  AST_RD_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && $past(rd_req)) |-> (rd_addr == $past(rd_addr) + ADDR_W'(1))); // R4
  AST_WR_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |-> (wr_addr == $past(wr_addr) + ADDR_W'(1))); // R5
endmodule

bind pixel_blit_top pixel_blit_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
  .wr_en(wr_en), .wr_addr(wr_addr), .busy(busy), .done(done), .err(err)
);

// File: tb/pixel_blit_top_tb_top.sv
module pixel_blit_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic          clk, rst_n, cfg_we;
  logic [2:0]    cfg_sel;
  logic [31:0]   cfg_wdata;
  logic          rd_req, wr_en, busy, done, err;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [7:0]    rd_data, wr_data;

  logic [7:0]  mem [4096];
  logic [31:0] exp_rd [$];
  logic [39:0] exp_wr [$];
  int checks = 0, fails = 0;
  int cyc = 0, acc_cnt = 0, done_cnt = 0, last_wr_cyc = 0;
  int reads_since = 0, wr_in_pix = 0;
  bit expect_writes = 0, finished = 0;

  pixel_blit_top dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .done(done), .err(err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk) if (rd_req) rd_data <= mem[rd_addr[11:0]];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // monitor: pops scoreboard entries as accesses appear
  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_req) begin
        acc_cnt++;
        reads_since++;
        if (exp_rd.size() == 0) chk(0, "R4 unexpected read", rd_addr, 0);
        else begin
          logic [31:0] e;
          e = exp_rd.pop_front();
          chk(rd_addr == e, "R4 read address", rd_addr, e);
        end
      end
      if (wr_en) begin
        acc_cnt++;
        if (wr_in_pix == 0) begin
          chk(reads_since == 3, "R7 reads before writes", reads_since, 3);
          reads_since = 0;
        end
        wr_in_pix = (wr_in_pix + 1) % 3;
        last_wr_cyc = cyc;
        if (exp_wr.size() == 0) chk(0, "R5 unexpected write", wr_addr, 0);
        else begin
          logic [39:0] e;
          e = exp_wr.pop_front();
          chk(wr_addr == e[39:8], "R5 write address", wr_addr, e[39:8]);
          chk(wr_data == e[7:0], "R6 write data", wr_data, e[7:0]);
        end
      end
      if (done) begin
        done_cnt++;
        if (expect_writes) chk(cyc == last_wr_cyc + 1, "R8 done timing", cyc, last_wr_cyc + 1);
      end
    end
  end

  task automatic cfg_write(input int sel, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic expect_xfer(input int src, input int dst, input int iw, input int ow, input int oh);
    int cols = ow / 2;
    expect_writes = (cols > 0 && oh > 0);
    reads_since = 0; wr_in_pix = 0;
    for (int y = 0; y < oh; y++)
      for (int x = 0; x < cols; x++)
        for (int k = 0; k < 3; k++) begin
          int sa = src + 4*x + y*(iw*4/2) + k;
          int da = dst + 3*x + y*(ow*3/2) + k;
          exp_rd.push_back(32'(sa));
          exp_wr.push_back({32'(da), mem[sa[11:0]]});
        end
  endtask

  task automatic load_cfg(input int src, input int dst, input int iw, input int ow, input int oh, input int fmt);
    cfg_write(0, 32'(src)); cfg_write(1, 32'(dst)); cfg_write(2, 32'(iw));
    cfg_write(3, 32'(ow));  cfg_write(4, 32'(oh));  cfg_write(5, 32'(fmt));
  endtask

  task automatic wait_done(input int d0, input string req);
    for (int i = 0; i < 4000 && done_cnt == d0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(done_cnt == d0 + 1, req, done_cnt - d0, 1);
    chk(exp_rd.size() == 0 && exp_wr.size() == 0, "R3 all pixels covered", exp_wr.size(), 0);
    chk(!busy, "R8 busy low after done", busy, 0);
  endtask

  task automatic run_xfer(input int src, input int dst, input int iw, input int ow, input int oh);
    int d0;
    load_cfg(src, dst, iw, ow, oh, 32'h10);
    expect_xfer(src, dst, iw, ow, oh);
    d0 = done_cnt;
    cfg_write(6, 32'h1);
    wait_done(d0, "R1 R3 single done per transfer");
    chk(!err, "R2 err clear on valid run", err, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int a0, d0;
    for (int i = 0; i < 4096; i++) mem[i] = 8'((i * 37 + 11) ^ (i >> 5));
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    chk({busy, done, err, rd_req, wr_en} == 5'b0, "R10 reset outputs", {busy, done, err, rd_req, wr_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 R5 R6 R11: several geometries, unequal strides
    run_xfer(32'h100, 32'h800, 8, 8, 3);
    run_xfer(32'h200, 32'h900, 12, 6, 2);
    run_xfer(32'h040, 32'hA00, 6, 5, 3);

    // R1: trigger with bit 0 clear
    a0 = acc_cnt; d0 = done_cnt;
    cfg_write(6, 32'h2);
    repeat (10) @(negedge clk);
    chk(!busy && acc_cnt == a0 && done_cnt == d0, "R1 bit0 clear ignored", acc_cnt - a0, 0);

    // R2: unsupported format pairs
    load_cfg(32'h100, 32'h800, 8, 8, 2, 32'h12);
    a0 = acc_cnt; d0 = done_cnt;
    cfg_write(6, 32'h1);
    repeat (10) @(negedge clk);
    chk(err == 1'b1, "R2 err on bad source format", err, 1);
    chk(acc_cnt == a0 && done_cnt == d0 && !busy, "R2 no activity on bad format", acc_cnt - a0, 0);
    cfg_write(5, 32'h00);
    cfg_write(6, 32'h1);
    repeat (10) @(negedge clk);
    chk(err == 1'b1 && acc_cnt == a0 && done_cnt == d0, "R2 bad destination format", acc_cnt - a0, 0);
    run_xfer(32'h300, 32'hB00, 4, 4, 2);

    // R3: empty geometries
    a0 = acc_cnt;
    run_xfer(32'h100, 32'hC00, 8, 8, 0);
    run_xfer(32'h100, 32'hC00, 8, 1, 4);
    chk(acc_cnt == a0, "R3 empty transfer makes no access", acc_cnt - a0, 0);

    // R9: trigger and config writes while busy
    load_cfg(32'h400, 32'hD00, 10, 8, 3, 32'h10);
    expect_xfer(32'h400, 32'hD00, 10, 8, 3);
    d0 = done_cnt;
    cfg_write(6, 32'h1);
    repeat (3) @(negedge clk);
    cfg_write(1, 32'hE00);
    cfg_write(3, 32'h20);
    cfg_write(6, 32'h1);
    wait_done(d0, "R9 retrigger ignored");
    a0 = acc_cnt;
    repeat (20) @(negedge clk);
    chk(acc_cnt == a0 && done_cnt == d0 + 1, "R9 no second transfer", acc_cnt - a0, 0);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule